// File: doc/BRIEF.md
# DSSS Symbol-to-Chip Spreader

This block turns a stream of data fields into a serial direct-sequence chip stream. Fields of one to `FIELD_BYTES` bytes arrive through a valid/ready handshake. A serializer breaks each field into bytes, least significant byte first. The spreading core then splits every byte into two 4-bit symbols, low nibble first. Each symbol is replaced by a fixed 32-chip pseudo-random code, and one chip leaves per pulse of a chip-rate enable. The nominal chip rate is 2 Mchip/s, which the enable divides down from the system clock.

The 16 codes are not stored. They are formed on the fly from one base code. The lower eight symbols rotate the base by four chip places per step. The upper eight symbols take the matching lower code and invert every odd-indexed chip.

A frame is the run of fields up to and including the one marked last. Inside a frame the core holds one byte in flight and takes the following byte only once the second symbol of the current byte has begun. When data keeps pace, bytes follow one another with no idle chip slot. If the feed runs dry inside a frame, an underrun pulse is raised. With no data the chip line is held at 0.

Top module: `dsss_spreader`

## Requirements
- R1: Each byte is sent as two symbols. The symbol formed by bits 3:0 is sent first, and the symbol formed by bits 7:4 is sent second.
- R2: `in_nbytes` (1 to FIELD_BYTES) gives the number of bytes in a field. Byte k is `in_data[8k+7:8k]`, and the bytes are sent for k = 0 upward. Bytes at or above the count are ignored and produce no chips.
- R3: Chip i (0..31) of symbol s is defined as follows. Let B be the symbol-0 code, which reads 11011001110000110101001000101110 for C0 through C31. Then chip i is B[(i - 4·(s mod 8)) mod 32], inverted when s ≥ 8 and i is odd.
- R4: Chips leave in the order C0 to C31, one per enable pulse. For a chip taken at an enable, `chip_valid` is high in the clock after that enable, with `chip_out` set to the chip. `sym_start` is high together with C0 of every symbol.
- R5: When the next byte is available in time, its first chip directly follows C31 of the previous byte's second symbol, with no enable pulse left without a chip.
- R6: The core takes a new byte only while idle or once the second symbol of the byte in flight has started. Consider two 1-byte fields sent from idle: `in_ready` rises again in the clock in which chip C31 of the first byte's first symbol is presented, which is the 32nd chip.
- R7: At an enable pulse with no chip to send, `chip_valid` stays low and `chip_out` stays 0. `chip_out` is 0 whenever `chip_valid` is low.
- R8: `underrun` pulses in the clock after each enable that finds no chip while a frame is open. A frame is open from a field with `in_last`=0 until a field with `in_last`=1 has been taken. No underrun is raised between frames.
- R9: After reset, `in_ready` is 1 and `chip_out`, `chip_valid`, `sym_start` and `underrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chip_en | input | 1 | Chip-rate enable, one clock wide per chip slot |
| in_valid | input | 1 | Field offered |
| in_ready | output | 1 | Field taken at this clock edge when in_valid is high |
| in_data | input | 8*FIELD_BYTES | Field bytes, byte 0 in bits 7:0 |
| in_nbytes | input | $clog2(FIELD_BYTES+1) | Number of valid bytes in the field |
| in_last | input | 1 | Field closes the frame |
| chip_out | output | 1 | Serial chip |
| chip_valid | output | 1 | chip_out carries a chip this clock |
| sym_start | output | 1 | Chip is C0 of a symbol |
| underrun | output | 1 | Enable slot missed inside an open frame |

## Verification
The hardest condition to reach is the byte hand-off at the end of a symbol pair. The next byte must already be waiting, or arrive in the very clock of the last chip, for the stream to stay gapless. Reaching this from the ports takes long runs of fields of mixed sizes, down to 1-byte fields, which keep the serializer and the core's one-byte holding slot swapping continually. A monitor then flags any enable pulse that passes without a chip while expected chips are still queued. The starved-frame case comes from a frame that is opened and then left unfed. The frame is later resumed and closed, to show that the underrun pulses stop once the frame ends.

// File: rtl/dsss_pkg.sv
// Shared constants for the DSSS spreader.
// Assumes the fixed 16-symbol, 32-chip code set; only the field width
// is a free parameter elsewhere.
package dsss_pkg;
    localparam int SYM_W    = 4;
    localparam int NUM_SYM  = 1 << SYM_W;
    localparam int CHIPS    = 32;
    localparam int IDX_W    = $clog2(CHIPS);
    localparam int BYTE_W   = 8;
    // rotation per symbol step within the lower half of the code set
    localparam int ROT_STEP = CHIPS / (NUM_SYM / 2);
    // symbol-0 code written C0 (leftmost, bit 31) .. C31 (rightmost, bit 0)
    localparam logic [CHIPS-1:0] BASE_LIT = 32'b11011001110000110101001000101110;

    typedef logic [CHIPS-1:0] chip_vec_t; // bit i holds chip Ci
endpackage

// File: rtl/dsss_code_gen.sv
// Combinational code generator: symbol -> 32-chip vector (bit i = Ci).
// Lower symbols rotate the base code by ROT_STEP chips per step toward
// higher indices; the upper half inverts odd chips of the lower twin.
// Assumes nothing about timing; pure logic.
module dsss_code_gen
    import dsss_pkg::*;
(
    input  logic [SYM_W-1:0] sym,
    output chip_vec_t        seq
);
    logic [IDX_W-1:0] shift;

    // rotation amount from the low symbol bits
    always_comb begin
        shift = IDX_W'(ROT_STEP) * IDX_W'(sym[SYM_W-2:0]);
    end

    for (genvar i = 0; i < CHIPS; i++) begin : g_chip
        localparam logic ODD = (i % 2) == 1;
        logic [IDX_W-1:0] src;
        // source chip index of base code, modulo CHIPS by wrap-around
        assign src    = IDX_W'(i) - shift;
        assign seq[i] = BASE_LIT[IDX_W'(CHIPS-1) - src] ^ (sym[SYM_W-1] & ODD);
    end
endmodule

// File: rtl/dsss_field_ser.sv
// Field serializer: holds one field and hands its bytes to the core,
// least significant byte first. A new field can be taken in the same
// clock the final byte of the held one is handed over.
// Assumes in_nbytes in 1..FIELD_BYTES; a count of 0 is sent as 1 byte.
module dsss_field_ser
    import dsss_pkg::*;
#(
    parameter int FIELD_BYTES = 4,
    localparam int CNT_W      = $clog2(FIELD_BYTES + 1),
    localparam int FW         = FIELD_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [FW-1:0]     in_data,
    input  logic [CNT_W-1:0]  in_nbytes,
    input  logic              in_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [BYTE_W-1:0] b_data,
    output logic              b_last
);
    logic             busy;
    logic [FW-1:0]    sh;
    logic [CNT_W-1:0] cnt;
    logic             last_f;
    logic             take_b;
    logic             final_b;
    logic             load;

    // handshake decode toward both sides
    always_comb begin
        take_b   = busy && b_ready;
        final_b  = take_b && (cnt == CNT_W'(1));
        in_ready = !busy || final_b;
        load     = in_valid && in_ready;
        b_valid  = busy;
        b_data   = sh[BYTE_W-1:0];
        b_last   = last_f && (cnt == CNT_W'(1));
    end

    // field register: load, then shift one byte per hand-over
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            sh     <= '0;
            cnt    <= '0;
            last_f <= 1'b0;
        end else if (load) begin
            busy   <= 1'b1;
            sh     <= in_data;
            cnt    <= (in_nbytes == '0) ? CNT_W'(1) : in_nbytes;
            last_f <= in_last;
        end else if (take_b) begin
            if (cnt == CNT_W'(1)) begin
                busy <= 1'b0;
            end else begin
                sh  <= sh >> BYTE_W;
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    if (FIELD_BYTES > 1) begin : g_chk
        // R2: after a non-final hand-over the next byte is the old byte 1
        a_r2_next_byte: assert property (@(posedge clk) disable iff (!rst_n)
            (take_b && (cnt != CNT_W'(1)) && !load) |=> (b_data == $past(sh[2*BYTE_W-1:BYTE_W])));
    end
    // R2: a held field does not change until a byte is taken
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !take_b) |=> ($stable(sh) && busy));
endmodule

// File: rtl/dsss_chip_seq.sv
// Spreading core: one byte in flight plus a one-byte holding slot.
// Emits low symbol then high symbol, chips C0..C31, one per chip_en.
// Takes a new byte while idle or once the second symbol has begun, so
// bytes chain with no empty chip slot. Tracks frame openness from the
// byte last flag to report starved enable slots.
// Assumes chip_en is at most one clock wide per chip slot.
module dsss_chip_seq
    import dsss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              b_valid,
    output logic              b_ready,
    input  logic [BYTE_W-1:0] b_data,
    input  logic              b_last,
    output logic              chip_out,
    output logic              chip_valid,
    output logic              sym_start,
    output logic              underrun
);
    logic              active;
    logic [BYTE_W-1:0] cur;
    logic              half;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] nxt;
    logic              nxt_full;
    logic              in_frame;
    logic [SYM_W-1:0]  sym;
    chip_vec_t         seq;
    logic              accept;
    logic              last_chip;
    logic              end_byte;

    // current symbol, handshake and end-of-byte decode
    always_comb begin
        sym       = half ? cur[BYTE_W-1:SYM_W] : cur[SYM_W-1:0];
        b_ready   = !active || (half && !nxt_full);
        accept    = b_valid && b_ready;
        last_chip = idx == IDX_W'(CHIPS-1);
        end_byte  = chip_en && active && last_chip && half;
    end

    dsss_code_gen u_code (
        .sym (sym),
        .seq (seq)
    );

    // output stage: one registered chip per enable, zero otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_out   <= 1'b0;
            chip_valid <= 1'b0;
            sym_start  <= 1'b0;
            underrun   <= 1'b0;
        end else begin
            chip_out   <= chip_en && active && seq[idx];
            chip_valid <= chip_en && active;
            sym_start  <= chip_en && active && (idx == '0);
            underrun   <= chip_en && !active && in_frame;
        end
    end

    // byte in flight: load, chip index, symbol half, chaining
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cur    <= '0;
            half   <= 1'b0;
            idx    <= '0;
        end else if (!active) begin
            if (accept) begin
                cur    <= b_data;
                active <= 1'b1;
                half   <= 1'b0;
                idx    <= '0;
            end
        end else if (chip_en) begin
            if (last_chip) begin
                idx  <= '0;
                half <= !half;
                if (half) begin
                    if (nxt_full) begin
                        cur <= nxt;
                    end else if (accept) begin
                        cur <= b_data;
                    end else begin
                        active <= 1'b0;
                    end
                end
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    // holding slot for the byte that follows the one in flight
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt      <= '0;
            nxt_full <= 1'b0;
        end else if (end_byte) begin
            nxt_full <= 1'b0;
        end else if (active && accept) begin
            nxt      <= b_data;
            nxt_full <= 1'b1;
        end
    end

    // frame tracking from the last flag of each accepted byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
        end else if (accept) begin
            in_frame <= !b_last;
        end
    end

    // R4: a chip appears only in the clock after an enable
    a_r4_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
        chip_valid |-> $past(chip_en));
    // R4: symbol start marks a real chip
    a_r4_start_is_chip: assert property (@(posedge clk) disable iff (!rst_n)
        sym_start |-> chip_valid);
    // R7: chip line is quiet without a chip
    a_r7_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_valid |-> !chip_out);
    // R8: an underrun slot carries no chip
    a_r8_underrun_no_chip: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> !chip_valid);
    // R6: a byte accepted mid-flight lands while the second symbol runs
    a_r6_take_in_second: assert property (@(posedge clk) disable iff (!rst_n)
        (active && accept && !end_byte) |=> (nxt_full && half));
    // R5: a waiting byte starts at the enable after the final chip
    a_r5_chain: assert property (@(posedge clk) disable iff (!rst_n)
        (end_byte && nxt_full) |=> (active && !half && idx == '0));
endmodule

// File: rtl/dsss_spreader.sv
// Top of the DSSS spreader: field serializer feeding the spreading core.
// Assumes chip_en pulses no faster than every few clocks so the
// serializer can refill between bytes.
module dsss_spreader
    import dsss_pkg::*;
#(
    parameter int FIELD_BYTES = 4,
    localparam int CNT_W      = $clog2(FIELD_BYTES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          chip_en,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [FIELD_BYTES*BYTE_W-1:0] in_data,
    input  logic [CNT_W-1:0]              in_nbytes,
    input  logic                          in_last,
    output logic                          chip_out,
    output logic                          chip_valid,
    output logic                          sym_start,
    output logic                          underrun
);
    logic              b_valid;
    logic              b_ready;
    logic [BYTE_W-1:0] b_data;
    logic              b_last;

    dsss_field_ser #(
        .FIELD_BYTES (FIELD_BYTES)
    ) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_nbytes (in_nbytes),
        .in_last   (in_last),
        .b_valid   (b_valid),
        .b_ready   (b_ready),
        .b_data    (b_data),
        .b_last    (b_last)
    );

    dsss_chip_seq u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .chip_en    (chip_en),
        .b_valid    (b_valid),
        .b_ready    (b_ready),
        .b_data     (b_data),
        .b_last     (b_last),
        .chip_out   (chip_out),
        .chip_valid (chip_valid),
        .sym_start  (sym_start),
        .underrun   (underrun)
    );
endmodule

// File: tb/dsss_spreader_tb.sv
`timescale 1ns/1ps
module dsss_spreader_tb;
    localparam int FB = 4;
    localparam int CW = $clog2(FB + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [FB*8-1:0] in_data = '0;
    logic [CW-1:0] in_nbytes = '0;
    logic          in_last = 1'b0;
    logic          chip_out, chip_valid, sym_start, underrun;

    int total = 0;
    int bad = 0;
    int chips_seen = 0;
    int urun_cnt = 0;
    int div = 0;
    bit streaming = 0;
    bit done = 0;
    bit exp_q[$];
    bit exp_st[$];
    logic [31:0] tbl [16];

    always #2.5 clk = ~clk;

    dsss_spreader #(.FIELD_BYTES(FB)) u_dut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_nbytes(in_nbytes), .in_last(in_last),
        .chip_out(chip_out), .chip_valid(chip_valid),
        .sym_start(sym_start), .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected chips for one byte: low symbol then high symbol (R1, R3)
    task automatic push_byte(input logic [7:0] b);
        for (int h = 0; h < 2; h++) begin
            logic [3:0] s;
            s = (h == 0) ? b[3:0] : b[7:4];
            for (int i = 0; i < 32; i++) begin
                exp_q.push_back(tbl[s][31-i]);
                exp_st.push_back(i == 0);
            end
        end
    endtask

    // offer a field and wait for it to be taken; queue its bytes (R2)
    task automatic send_field(input logic [FB*8-1:0] d, input int n, input bit last);
        for (int k = 0; k < n; k++) push_byte(d[8*k +: 8]);
        @(negedge clk);
        in_valid  = 1'b1;
        in_data   = d;
        in_nbytes = CW'(n);
        in_last   = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (80) @(negedge clk);
    endtask

    // monitor and enable generator on the falling edge
    always @(negedge clk) begin
        logic ce_used;
        ce_used = chip_en;
        if (rst_n) begin
            if (chip_valid) begin
                chips_seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R2 extra chip", 1, 0);
                end else begin
                    bit e, st;
                    e  = exp_q.pop_front();
                    st = exp_st.pop_front();
                    check(chip_out == e, "R3 chip value", chip_out, e);
                    check(sym_start == st, "R4 symbol start", sym_start, st);
                end
            end else if (ce_used) begin
                check(chip_out == 1'b0, "R7 idle chip line", chip_out, 0);
                if (streaming) check(0, "R5 gap in stream", 0, 1);
            end
            if (underrun) urun_cnt++;
            if (exp_q.size() == 0) streaming = 0;
            else if (chip_valid) streaming = 1;
        end
        div = (div == 3) ? 0 : div + 1;
        chip_en = rst_n && (div == 3);
    end

    initial begin
        // reference code table, C0 leftmost
        tbl[0]  = 32'b11011001110000110101001000101110;
        tbl[1]  = 32'b11101101100111000011010100100010;
        tbl[2]  = 32'b00101110110110011100001101010010;
        tbl[3]  = 32'b00100010111011011001110000110101;
        tbl[4]  = 32'b01010010001011101101100111000011;
        tbl[5]  = 32'b00110101001000101110110110011100;
        tbl[6]  = 32'b11000011010100100010111011011001;
        tbl[7]  = 32'b10011100001101010010001011101101;
        tbl[8]  = 32'b10001100100101100000011101111011;
        tbl[9]  = 32'b10111000110010010110000001110111;
        tbl[10] = 32'b01111011100011001001011000000111;
        tbl[11] = 32'b01110111101110001100100101100000;
        tbl[12] = 32'b00000111011110111000110010010110;
        tbl[13] = 32'b01100000011101111011100011001001;
        tbl[14] = 32'b10010110000001110111101110001100;
        tbl[15] = 32'b11001001011000000111011110111000;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
        check(chip_valid == 1'b0, "R9 chip_valid", chip_valid, 0);
        check(chip_out == 1'b0, "R9 chip_out", chip_out, 0);
        check(sym_start == 1'b0, "R9 sym_start", sym_start, 0);
        check(underrun == 1'b0, "R9 underrun", underrun, 0);

        // R6: two 1-byte fields from idle; ready returns at chip 32
        send_field(32'hEEEE_EEA5, 1, 1'b0);
        send_field(32'h7777_773C, 1, 1'b0);
        while (!in_ready) @(negedge clk);
        #1;
        check(chips_seen == 32, "R6 ready at second symbol", chips_seen, 32);

        // R1 R2 R5: all nibbles in both places, fields of 1..4 bytes,
        // unused upper bytes filled with junk that must not be sent
        begin
            int j;
            int n;
            j = 0;
            n = 1;
            while (j < 16) begin
                logic [FB*8-1:0] d;
                d = 32'hDEAD_BEEF;
                for (int k = 0; k < n; k++) d[8*k +: 8] = {4'(15 - (j + k)), 4'(j + k)};
                send_field(d, n, (j + n) >= 16);
                j = j + n;
                n = (n == 4) ? 1 : n + 1;
            end
        end
        drain();
        check(exp_q.size() == 0, "R2 all bytes sent", exp_q.size(), 0);
        check(urun_cnt == 0, "R8 no underrun when fed", urun_cnt, 0);

        // R3 R5: every byte value, 4-byte fields, one frame
        for (int f = 0; f < 64; f++) begin
            logic [FB*8-1:0] d;
            for (int k = 0; k < 4; k++) d[8*k +: 8] = 8'(4*f + k);
            send_field(d, 4, f == 63);
        end
        drain();
        check(exp_q.size() == 0, "R3 sweep complete", exp_q.size(), 0);
        check(urun_cnt == 0, "R8 no underrun in sweep", urun_cnt, 0);
        check(chips_seen == 32*2*(2 + 16 + 256), "R4 chip count", chips_seen, 32*2*(2 + 16 + 256));

        // R8: open frame starved, then resumed and closed
        send_field(32'h0000_5A81, 2, 1'b0);
        drain();
        check(urun_cnt > 0, "R8 underrun raised", urun_cnt, 1);
        send_field(32'h0000_00F0, 1, 1'b1);
        drain();
        urun_cnt = 0;
        repeat (200) @(negedge clk);
        check(urun_cnt == 0, "R8 quiet after close", urun_cnt, 0);
        check(chip_valid == 1'b0 && chip_out == 1'b0, "R7 idle after frame", chip_out, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule